// File: doc/BRIEF.md
# Byte and Page Write Controller for an On-Chip Nonvolatile Array

This block stands between a serial-bus register front end and a 2048-byte storage array that stands in for nonvolatile cells. Writes go first into a 64-byte page buffer. A write transaction is a run of write beats: the first beat sets the byte address, and each later beat stores its byte at the next offset of the same page. A stop strobe ends the transaction. The stop then either commits the buffered bytes to the array or discards them.

A commit occupies the controller for a fixed number of clock cycles, which stands for the programming time of the cells. While the commit runs, the busy output is high and every request is refused. A 3-bit protect level marks an upper part of the array as read-only. A transaction that touches a protected byte is dropped in full. Reads return the array byte one cycle after the request.

The front end gives each request a one-cycle pulse on `req_valid` and receives one answer on the next cycle: either an acknowledge or a refusal.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, `busy`, `resp_ack`, `resp_nack` and `rd_valid` are all low.
- R2: A read request that is accepted gives `resp_ack` and `rd_valid` high on the next cycle. At that point `rd_data` holds the array byte at `req_addr`.
- R3: A write transaction of one beat followed by a stop changes only that byte of the array.
- R4: A beat with `req_start` high opens a transaction. A write beat that arrives while no transaction is open also opens one. Each later beat stores its byte at the previous offset plus one. A full 64-beat page lands at 64 consecutive addresses.
- R5: The offset wraps from 63 to 0 inside the same page, and never carries into the next page. When a transaction has more than 64 beats, the later beats overwrite the earlier bytes at the same offsets. Bytes outside the page are not changed.
- R6: A stop that commits raises `busy` on the next cycle. `busy` then stays high for exactly WR_CYCLES cycles.
- R7: Any request that arrives while `busy` is high gets `resp_nack` on the next cycle and has no effect. This includes a request in the last busy cycle. A refused write opens no transaction. The first request after `busy` falls is served.
- R8: Protect level k (a value from 0 to 7 on `lock_cfg`) protects every address at or above 2048 − (2048 >> (7 − k)) when k is not 0. So level 1 protects the top 32 bytes, each higher level doubles the protected region, and level 7 protects the whole array. Level 0 protects nothing.
- R9: When any beat of a transaction fell on a protected address, the stop discards the whole transaction. No commit starts, `busy` stays low, and the array keeps its contents.
- R10: Every request gets exactly one of `resp_ack` or `resp_nack` on the next cycle. A cycle without a request is followed by a cycle with neither.
- R11: A stop with no open transaction starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_write | input | 1 | 1 = write beat, 0 = read |
| req_start | input | 1 | Write beat opens a new transaction at `req_addr` |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_stop | input | 1 | End of write transaction; honoured only when `req_valid` is low |
| lock_cfg | input | 3 | Protect level, sampled with each write beat |
| resp_ack | output | 1 | Request accepted (one cycle after it) |
| resp_nack | output | 1 | Request refused (one cycle after it) |
| rd_valid | output | 1 | `rd_data` carries read data |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Commit in progress |

## Verification
The collision that matters is the end of a commit meeting a new request. The busy counter runs out on the same clock edge at which a request, issued in the last busy cycle, is sampled. That request must be refused even though `busy` is already low when its answer appears. The next request must then be served.

The bench provokes this by counting exactly WR_CYCLES − 1 cycles after the stop and then issuing a read. It checks for a refusal alongside a low `busy`, and then for an acknowledged read of the correct byte. A second overlap is a write refused during busy followed by a stop. The bench checks that no commit starts and that the refused byte never reaches the array.

// File: rtl/eew_pkg.sv
package eew_pkg;

  localparam int unsigned EEW_ADDR_W = 11;
  localparam int unsigned EEW_DATA_W = 8;
  localparam int unsigned EEW_PAGE_W = 6;
  localparam int unsigned EEW_LOCK_W = 3;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_ACK  = 2'd1,
    RSP_NACK = 2'd2
  } rsp_e;

  // Number of upper address bits that must all be one for an address to be
  // protected at the given level (level 0 is handled by the caller).
  function automatic int unsigned lock_top_bits(int unsigned cfg, int unsigned lock_w);
    return ((32'd1 << lock_w) - 32'd1) - cfg;
  endfunction

endpackage

// File: rtl/eew_lock_decode.sv
module eew_lock_decode #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned LOCK_W = 3
) (
  input  logic [LOCK_W-1:0] cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);

  int unsigned       top_n;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    top_n = eew_pkg::lock_top_bits(32'(cfg_i), LOCK_W);
    if (top_n > ADDR_W) begin
      top_n = ADDR_W;
    end
    low_mask = {ADDR_W{1'b1}} >> top_n;
    locked_o = (cfg_i != '0) && (&(addr_i | low_mask));
  end

endmodule

// File: rtl/eew_page_buf.sv
module eew_page_buf #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_i,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     lock_hit_i,
  input  logic                     close_i,
  input  logic                     drop_i,
  input  logic                     flush_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic                     open_o,
  output logic                     hit_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic [ADDR_W-1:0]        eff_addr_o,
  output logic [DATA_W-1:0]        byte_o,
  output logic                     vld_o
);

  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned PSEL_W     = ADDR_W - PAGE_W;

  logic                  open_q, open_d;
  logic                  hit_q, hit_d;
  logic [PSEL_W-1:0]     page_q, page_d;
  logic [PAGE_W-1:0]     ptr_q, ptr_d;
  logic [PAGE_BYTES-1:0] vld_q, vld_d;
  logic [DATA_W-1:0]     store_q [PAGE_BYTES];

  logic                  fresh;
  logic [PSEL_W-1:0]     wr_page;
  logic [PAGE_W-1:0]     wr_off;

  // Beat placement: a fresh beat takes its address from the bus; a follow-on
  // beat takes the running pointer inside the latched page.
  always_comb begin
    fresh      = start_i || !open_q;
    wr_page    = fresh ? addr_i[ADDR_W-1:PAGE_W] : page_q;
    wr_off     = fresh ? addr_i[PAGE_W-1:0]      : ptr_q;
    eff_addr_o = {wr_page, wr_off};
  end

  always_comb begin
    open_d = open_q;
    hit_d  = hit_q;
    page_d = page_q;
    ptr_d  = ptr_q;
    vld_d  = vld_q;
    if (acc_i) begin
      open_d = 1'b1;
      page_d = wr_page;
      ptr_d  = wr_off + PAGE_W'(1);
      if (fresh) begin
        vld_d = '0;
        hit_d = lock_hit_i;
      end else begin
        hit_d = hit_q || lock_hit_i;
      end
      vld_d[wr_off] = 1'b1;
    end
    if (close_i) begin
      open_d = 1'b0;
    end
    if (drop_i) begin
      open_d = 1'b0;
      hit_d  = 1'b0;
      vld_d  = '0;
    end
    if (flush_i) begin
      vld_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      hit_q  <= 1'b0;
      page_q <= '0;
      ptr_q  <= '0;
      vld_q  <= '0;
    end else begin
      open_q <= open_d;
      hit_q  <= hit_d;
      page_q <= page_d;
      ptr_q  <= ptr_d;
      vld_q  <= vld_d;
    end
  end

  // Byte storage carries no reset; the valid mask qualifies it.
  always_ff @(posedge clk) begin
    if (acc_i) begin
      store_q[wr_off] <= data_i;
    end
  end

  assign open_o = open_q;
  assign hit_o  = hit_q;
  assign page_o = page_q;
  assign byte_o = store_q[rd_idx_i];
  assign vld_o  = vld_q[rd_idx_i];

endmodule

// File: rtl/eew_commit_seq.sv
module eew_commit_seq #(
  parameter int unsigned WR_CYCLES = 625000,
  parameter int unsigned PAGE_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              step_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);

  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned CNT_W      = $clog2(WR_CYCLES + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // One buffer slot is copied per cycle during the first PAGE_BYTES cycles
  // of the busy window; WR_CYCLES must be at least PAGE_BYTES.
  always_comb begin
    step_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    idx_o  = cnt_q[PAGE_W-1:0];
    done_o = busy_q && (cnt_q == CNT_W'(WR_CYCLES - 1));
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (launch_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/eew_array.sv
module eew_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      cells[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_q <= cells[raddr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/eeprom_wr_ctrl.sv
module eeprom_wr_ctrl #(
  parameter int unsigned ADDR_W    = eew_pkg::EEW_ADDR_W,
  parameter int unsigned DATA_W    = eew_pkg::EEW_DATA_W,
  parameter int unsigned PAGE_W    = eew_pkg::EEW_PAGE_W,
  parameter int unsigned LOCK_W    = eew_pkg::EEW_LOCK_W,
  parameter int unsigned WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_stop,
  input  logic [LOCK_W-1:0] lock_cfg,
  output logic              resp_ack,
  output logic              resp_nack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  import eew_pkg::*;

  localparam int unsigned PSEL_W = ADDR_W - PAGE_W;

  logic              busy_w;
  logic              accept, wr_acc, rd_acc;
  logic              ctl_ok, launch, drop;
  logic              buf_open, buf_hit, buf_vld;
  logic [PSEL_W-1:0] buf_page;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] buf_byte;
  logic              eff_locked;
  logic              cm_step, cm_done;
  logic [PAGE_W-1:0] cm_idx;
  logic              arr_we;

  rsp_e              rsp_q, rsp_d;
  logic              rdv_q, rdv_d;

  // Request admission: nothing is accepted while a commit runs.
  always_comb begin
    accept = req_valid && !busy_w;
    wr_acc = accept && req_write;
    rd_acc = accept && !req_write;
    ctl_ok = req_stop && !req_valid && !busy_w && buf_open;
    launch = ctl_ok && !buf_hit;
    drop   = ctl_ok && buf_hit;
  end

  always_comb begin
    if (!req_valid) begin
      rsp_d = RSP_NONE;
    end else if (busy_w) begin
      rsp_d = RSP_NACK;
    end else begin
      rsp_d = RSP_ACK;
    end
    rdv_d = rd_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= RSP_NONE;
      rdv_q <= 1'b0;
    end else begin
      rsp_q <= rsp_d;
      rdv_q <= rdv_d;
    end
  end

  eew_lock_decode #(
    .ADDR_W (ADDR_W),
    .LOCK_W (LOCK_W)
  ) u_lock (
    .cfg_i    (lock_cfg),
    .addr_i   (eff_addr),
    .locked_o (eff_locked)
  );

  eew_page_buf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PAGE_W (PAGE_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (wr_acc),
    .start_i    (req_start),
    .addr_i     (req_addr),
    .data_i     (req_wdata),
    .lock_hit_i (eff_locked),
    .close_i    (launch),
    .drop_i     (drop),
    .flush_i    (cm_done),
    .rd_idx_i   (cm_idx),
    .open_o     (buf_open),
    .hit_o      (buf_hit),
    .page_o     (buf_page),
    .eff_addr_o (eff_addr),
    .byte_o     (buf_byte),
    .vld_o      (buf_vld)
  );

  eew_commit_seq #(
    .WR_CYCLES (WR_CYCLES),
    .PAGE_W    (PAGE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch),
    .busy_o   (busy_w),
    .step_o   (cm_step),
    .idx_o    (cm_idx),
    .done_o   (cm_done)
  );

  assign arr_we = cm_step && buf_vld;

  eew_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk     (clk),
    .we_i    (arr_we),
    .waddr_i ({buf_page, cm_idx}),
    .wdata_i (buf_byte),
    .re_i    (rd_acc),
    .raddr_i (req_addr),
    .rdata_o (rd_data)
  );

  assign resp_ack  = (rsp_q == RSP_ACK);
  assign resp_nack = (rsp_q == RSP_NACK);
  assign rd_valid  = rdv_q;
  assign busy      = busy_w;

endmodule

// File: rtl/eew_ctrl_chk.sv
module eew_ctrl_chk #(
  parameter int unsigned WR_CYCLES = 625000
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_stop,
  input logic resp_ack,
  input logic resp_nack,
  input logic rd_valid,
  input logic busy
);

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else if (busy) begin
      run_q <= run_q + 1;
    end else begin
      run_q <= 0;
    end
  end

  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (resp_ack ^ resp_nack));

  // R10
  quiet_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_ack && !resp_nack));

  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> resp_nack);

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == WR_CYCLES));

  // R11
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req_stop) && !$past(req_valid)));

  // R2
  rdv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> resp_ack);

endmodule

bind eeprom_wr_ctrl eew_ctrl_chk #(
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_stop  (req_stop),
  .resp_ack  (resp_ack),
  .resp_nack (resp_nack),
  .rd_valid  (rd_valid),
  .busy      (busy)
);

// File: tb/sim_eeprom_wr_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_wr_ctrl;

  localparam int W     = 80;
  localparam int DEPTH = 2048;

  logic       clk;
  logic       rst_n;
  logic       req_valid, req_write, req_start, req_stop;
  logic [10:0] req_addr;
  logic [7:0]  req_wdata;
  logic [2:0]  lock_cfg;
  logic       resp_ack, resp_nack, rd_valid, busy;
  logic [7:0]  rd_data;

  int n_chk;
  int n_err;

  logic [7:0] mdl   [DEPTH];
  bit         known [DEPTH];

  eeprom_wr_ctrl #(.WR_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_start(req_start), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_stop(req_stop), .lock_cfg(lock_cfg), .resp_ack(resp_ack),
    .resp_nack(resp_nack), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_locked(int a, int k);
    if (k == 0) return 1'b0;
    return a >= (DEPTH - (DEPTH >> (7 - k)));
  endfunction

  task automatic beat(bit st, int a, int d, bit exp_ack, string tag);
    req_valid = 1'b1; req_write = 1'b1; req_start = st;
    req_addr = 11'(a); req_wdata = 8'(d);
    step();
    req_valid = 1'b0; req_write = 1'b0; req_start = 1'b0;
    if (exp_ack) chk(resp_ack && !resp_nack, tag, {resp_ack, resp_nack}, 2);
    else         chk(resp_nack && !resp_ack && !rd_valid, tag, {resp_ack, resp_nack}, 1);
  endtask

  task automatic stop_pulse();
    req_stop = 1'b1;
    step();
    req_stop = 1'b0;
  endtask

  // R4 R5 R6 R9: buffered write of n beats; the bench computes the page wrap
  task automatic page_write(int a, int n, int seed, bit commit_exp, string tag);
    int run;
    for (int i = 0; i < n; i++) begin
      int ad;
      int dv;
      ad = (a & ~63) | ((a + i) & 63);
      dv = (seed + i * 13) & 255;
      beat(i == 0, ad, dv, 1'b1, tag);
      if (commit_exp) begin
        mdl[ad]   = 8'(dv);
        known[ad] = 1'b1;
      end
    end
    stop_pulse();
    chk(busy == commit_exp, commit_exp ? "R6 busy after stop" : "R9 locked no busy",
        busy, commit_exp);
    run = 0;
    while (busy && run < 1000) begin
      run++;
      step();
    end
    if (commit_exp) chk(run == W, "R6 busy length", run, W);
  endtask

  task automatic read_chk(int a, string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'(a);
    step();
    req_valid = 1'b0;
    chk(rd_valid && resp_ack && !resp_nack, "R2 read handshake", {rd_valid, resp_ack}, 3);
    if (known[a]) chk(rd_data == mdl[a], tag, rd_data, mdl[a]);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_start = 1'b0; req_stop = 1'b0;
    req_addr = '0; req_wdata = '0; lock_cfg = '0;
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(!busy && !resp_ack && !resp_nack && !rd_valid, "R1 reset outputs",
        {busy, resp_ack, resp_nack, rd_valid}, 0);
    step();
    // R10 no answer without request
    chk(!resp_ack && !resp_nack, "R10 idle quiet", {resp_ack, resp_nack}, 0);

    // R4 fill every page with full 64-beat transactions, read all back
    for (int p = 0; p < DEPTH / 64; p++) page_write(p * 64, 64, p * 5 + 1, 1'b1, "R4 page beat");
    for (int a = 0; a < DEPTH; a++) read_chk(a, "R4 page data");

    // R3 single byte, neighbours unchanged
    page_write(12'h123, 1, 8'hA5, 1'b1, "R3 single beat");
    read_chk(12'h122, "R3 lower neighbour");
    read_chk(12'h123, "R3 written byte");
    read_chk(12'h124, "R3 upper neighbour");

    // R5 wrap inside the page
    page_write(12'h23C, 8, 8'h40, 1'b1, "R5 wrap beat");
    for (int i = 0; i < 4; i++) read_chk(12'h23C + i, "R5 page tail");
    for (int i = 0; i < 5; i++) read_chk(12'h200 + i, "R5 wrapped head");
    read_chk(12'h240, "R5 next page untouched");
    read_chk(12'h1FF, "R5 previous page untouched");

    // R5 overlong transaction: later beats overwrite
    page_write(12'h300, 70, 8'h90, 1'b1, "R5 overflow beat");
    for (int i = 0; i < 64; i++) read_chk(12'h300 + i, "R5 overflow data");
    read_chk(12'h340, "R5 overflow next page");

    // R7 requests during busy, last busy cycle, first cycle after
    beat(1'b1, 12'h0C0, 8'h3C, 1'b1, "R3 beat");
    stop_pulse();
    mdl[12'h0C0] = 8'h3C;
    chk(busy, "R6 busy raised", busy, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h100;
    step();
    req_valid = 1'b0;
    chk(resp_nack && !resp_ack && !rd_valid, "R7 read refused",
        {resp_ack, resp_nack, rd_valid}, 2);
    beat(1'b1, 12'h124, 8'h00, 1'b0, "R7 write refused");
    repeat (W - 3) step();
    chk(busy, "R7 still busy before last cycle", busy, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h0C0;
    step();
    req_valid = 1'b0;
    chk(resp_nack && !resp_ack, "R7 last busy cycle refused", {resp_ack, resp_nack}, 1);
    chk(!busy, "R6 busy fell", busy, 0);
    read_chk(12'h0C0, "R7 first read after busy");
    read_chk(12'h124, "R7 refused write had no effect");

    // R11 stop with nothing open (refused beat opened nothing)
    stop_pulse();
    chk(!busy, "R11 empty stop", busy, 0);
    step();
    chk(!busy, "R11 empty stop later", busy, 0);
    read_chk(12'h124, "R11 array unchanged");

    // R8 R9 protect-level sweep
    for (int k = 0; k < 8; k++) begin
      int base;
      lock_cfg = 3'(k);
      base = (k == 0) ? DEPTH : DEPTH - (DEPTH >> (7 - k));
      if (k == 0) begin
        page_write(DEPTH - 1, 1, 8'h11, 1'b1, "R8 level0 top write");
        read_chk(DEPTH - 1, "R8 level0 nothing protected");
      end else begin
        chk(is_locked(base, k) && !is_locked(base - 1, k), "R8 bench boundary", k, k);
        page_write(base, 1, 8'h5A + k, 1'b0, "R9 locked beat");
        read_chk(base, "R9 locked byte unchanged");
        if (base > 0) begin
          page_write(base - 1, 1, 8'h70 + k, 1'b1, "R8 below boundary beat");
          read_chk(base - 1, "R8 below boundary written");
        end
        if (k == 1) begin
          page_write(base - 1, 2, 8'hE0, 1'b0, "R9 straddle beat");
          read_chk(base - 1, "R9 straddle dropped whole");
        end
      end
    end
    lock_cfg = '0;

    step();
    chk(!resp_ack && !resp_nack && !busy, "R10 final idle", {resp_ack, resp_nack, busy}, 0);

    summary();
    $finish;
  end

endmodule